// File: doc/BRIEF.md
# Touch Controller Interrupt Status Register

This block holds the sticky interrupt status of a touch-sensing peripheral and drives its interrupt line to the host. Single-cycle event pulses latch into status bits. These pulses come from touch detection, coordinate data readiness, touch release, calculation error and three port-activity sources. The host reads the status over a simple synchronous register bus. A read returns a snapshot of the status, and only the bits in that snapshot are cleared. An event that lands in the same cycle as the read stays pending for the next read.

Some bits do not follow plain clear-on-read, and the rule depends on the acquisition mode:

- **Data-ready bit:** in the timer-driven and host-read-controlled modes, it waits for the host to read the coordinate data.
- **Touch bit:** in pen-down mode, it holds until the pen-removed pulse arrives. The interrupt output is silenced in that mode.

An enable register sits beside the status register and selects which bits raise the interrupt.

Top module: `isr_unit`

## Requirements
- R1: After reset, the status and enable registers are 0x00, `irq` is low and `rdata` is 0x00. Bit 4 of both registers always reads 0.
- R2: A write to the status address has no effect on the status register.
- R3: Each event pulse sets its own status bit whether or not the matching enable bit is set. The bit positions are: `ev_err` bit 7, `ev_rel` bit 6, `ev_port[2]` bit 5, `ev_port[1]` bit 3, `ev_port[0]` bit 2, `ev_data` bit 1, `ev_touch` bit 0.
- R4: A read at `STAT_ADDR` puts the status, as it stood before that clock edge, on `rdata` after the edge. That same edge clears exactly the returned bits that are clearable in the current mode.
- R5: A read at `IEN_ADDR` returns the enable register and clears the status register under the same snapshot rule as R4.
- R6: In modes 0 (timer-driven) and 1 (host-read-controlled), a status or enable read leaves bit 1 set. A `data_rd` pulse clears bit 1.
- R7: In mode 2 (acquisition), bit 1 clears on a status read, an enable read, or a `data_rd` pulse.
- R8: In mode 3 (pen-down), bit 0 survives reads and clears only on a `pen_up` pulse. All other bits still clear on read.
- R9: `irq` is registered. It equals the OR over bits of (status AND enable) from the previous cycle. Writes to the enable register drop bit 4.
- R10: While mode is 3, `irq` is driven low one cycle later, whatever the status and enable contents.
- R11: When a set and a clear hit the same bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_touch | input | 1 | Touch detected pulse |
| ev_data | input | 1 | Coordinate data ready pulse |
| ev_rel | input | 1 | Touch release pulse |
| ev_err | input | 1 | Calculation error pulse |
| ev_port | input | 3 | Port activity pulses, ports 2..0 |
| data_rd | input | 1 | Host has read the coordinate data |
| pen_up | input | 1 | Pen removed |
| mode | input | 2 | 0 timer, 1 host-read, 2 acquisition, 3 pen-down |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with its default addresses: status at 0x0A and enable at 0x0B, with an 8-bit address. Random traffic therefore hits both registers as well as unused addresses, and unused addresses must return zero. Events are generated at a high rate alongside frequent reads, so events coincide with read clears and with `data_rd` or `pen_up`. Occasional mode changes take every clearing rule through the same traffic.

// File: rtl/isr_unit.sv
module isr_unit #(
  parameter int          AW        = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'h0A,
  parameter logic [AW-1:0] IEN_ADDR  = 8'h0B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_touch,
  input  logic          ev_data,
  input  logic          ev_rel,
  input  logic          ev_err,
  input  logic [2:0]    ev_port,
  input  logic          data_rd,
  input  logic          pen_up,
  input  logic [1:0]    mode,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq
);
  localparam logic [7:0] RSV      = 8'h10;
  localparam logic [1:0] MODE_ACQ = 2'd2;
  localparam logic [1:0] MODE_PEN = 2'd3;

  logic [7:0] st, ier;

  wire pen     = (mode == MODE_PEN);
  wire rd_stat = rd_en && (addr == STAT_ADDR);
  wire rd_ien  = rd_en && (addr == IEN_ADDR);
  wire wr_ien  = wr_en && (addr == IEN_ADDR);

  wire [7:0] set_v   = {ev_err, ev_rel, ev_port[2], 1'b0, ev_port[1], ev_port[0], ev_data, ev_touch};
  wire [7:0] rd_mask = 8'hEC | {6'b0, (mode == MODE_ACQ) || pen, !pen};
  wire [7:0] ev_clr  = {6'b0, data_rd, pen && pen_up};
  wire [7:0] clr_v   = ({8{rd_stat || rd_ien}} & st & rd_mask) | ev_clr;
  wire [7:0] st_nx   = ((st & ~clr_v) | set_v) & ~RSV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= '0;
      ier   <= '0;
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      st  <= st_nx;
      irq <= !pen && |(st & ier);
      if (wr_ien) ier <= wdata & ~RSV;
      if (rd_en)  rdata <= rd_stat ? st : (rd_ien ? ier : 8'h00);
    end
  end
endmodule

// File: rtl/isr_unit_chk.sv
module isr_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] st,
  input logic [7:0] ier,
  input logic [7:0] set_v,
  input logic [1:0] mode,
  input logic       data_rd,
  input logic       pen_up,
  input logic [7:0] rdata,
  input logic       irq
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[4] && !st[4] && !ier[4]);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != 8'h00) |=> ((st & $past(set_v)) == $past(set_v)));

  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode <= 2'd1 && st[1] && !data_rd) |=> st[1]);

  a_r8_pen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && st[0] && !pen_up) |=> st[0]);

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(st & ier)));

  a_r10_pen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |=> !irq);
endmodule

bind isr_unit isr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .ier(ier), .set_v(set_v), .mode(mode),
  .data_rd(data_rd), .pen_up(pen_up), .rdata(rdata), .irq(irq)
);

// File: tb/sim_isr_unit.sv
module sim_isr_unit;
  logic clk = 0, rst_n = 0;
  logic ev_touch = 0, ev_data = 0, ev_rel = 0, ev_err = 0;
  logic [2:0] ev_port = 0;
  logic data_rd = 0, pen_up = 0, rd_en = 0, wr_en = 0;
  logic [1:0] mode = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic irq;

  localparam logic [7:0] SA = 8'h0A, IA = 8'h0B;

  int checks = 0, fails = 0;
  logic [7:0] m_st = 0, m_ier = 0, m_rd = 0;
  logic m_irq = 0;

  always #10 clk = ~clk;

  isr_unit u0 (.clk(clk), .rst_n(rst_n), .ev_touch(ev_touch), .ev_data(ev_data),
    .ev_rel(ev_rel), .ev_err(ev_err), .ev_port(ev_port), .data_rd(data_rd),
    .pen_up(pen_up), .mode(mode), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [7:0] events_vec();
    return {ev_err, ev_rel, ev_port[2], 1'b0, ev_port[1], ev_port[0], ev_data, ev_touch};
  endfunction

  function automatic logic [7:0] clearable(logic [1:0] md);
    logic [7:0] m = 8'hEC;
    if (md != 2'd3) m[0] = 1'b1;
    if (md >= 2'd2) m[1] = 1'b1;
    return m;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    logic [7:0] nst, clr;
    logic rd_hit;
    rd_hit = rd_en && (addr == SA || addr == IA);
    clr = (rd_hit ? (m_st & clearable(mode)) : 8'h00);
    if (data_rd) clr[1] = 1'b1;
    if (pen_up && mode == 2'd3) clr[0] = 1'b1;
    nst = (m_st & ~clr) | events_vec();
    m_irq = (mode != 2'd3) && |(m_st & m_ier);
    if (rd_en) m_rd = (addr == SA) ? m_st : ((addr == IA) ? m_ier : 8'h00);
    if (wr_en && addr == IA) m_ier = wdata & 8'hEF;
    m_st = nst;
    @(posedge clk); #1;
    chk("R4 rdata", rdata, m_rd);
    chk("R9 irq", {7'b0, irq}, {7'b0, m_irq});
    {ev_touch, ev_data, ev_rel, ev_err, ev_port, data_rd, pen_up, rd_en, wr_en} = '0;
  endtask

  task automatic rd(logic [7:0] a); rd_en = 1; addr = a; step(); endtask
  task automatic wr(logic [7:0] a, logic [7:0] d); wr_en = 1; addr = a; wdata = d; step(); endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    wr(SA, 8'hFF); rd(SA); chk("R2 write ignored", rdata, 8'h00);
    ev_touch = 1; ev_err = 1; step();
    rd(SA); chk("R3 set without enable", rdata, 8'h81);
    chk("R3 no irq when disabled", {7'b0, irq}, 8'h00);
    rd(SA); chk("R4 cleared after read", rdata, 8'h00);
    ev_port = 3'b111; step();
    ev_err = 1; rd(SA); chk("R4 snapshot", rdata, 8'h2C);
    rd(SA); chk("R4 late event kept", rdata, 8'h80);
    wr(IA, 8'h02);
    ev_data = 1; step(); chk("R9 irq delay", {7'b0, irq}, 8'h00);
    step(); chk("R9 irq asserted", {7'b0, irq}, 8'h01);
    rd(SA); chk("R6 data read once", rdata, 8'h02);
    rd(SA); chk("R6 data kept after read", rdata, 8'h02);
    mode = 2'd1; rd(SA); chk("R6 host-read mode kept", rdata, 8'h02);
    data_rd = 1; step(); rd(SA); chk("R6 data_rd clears", rdata, 8'h00);
    mode = 2'd0;
    ev_touch = 1; step(); wr(IA, 8'hFF);
    rd(IA); chk("R9 enable bit4 dropped", rdata, 8'hEF);
    rd(SA); chk("R5 enable read clears", rdata, 8'h00);
    mode = 2'd2; ev_data = 1; step();
    rd(SA); chk("R7 acq read", rdata, 8'h02);
    rd(SA); chk("R7 acq cleared", rdata, 8'h00);
    ev_data = 1; step(); data_rd = 1; step();
    rd(SA); chk("R7 data_rd clears", rdata, 8'h00);
    mode = 2'd3; ev_touch = 1; ev_port = 3'b001; step(); step();
    chk("R10 pen mode quiet", {7'b0, irq}, 8'h00);
    rd(SA); chk("R8 pen read", rdata, 8'h05);
    rd(SA); chk("R8 touch held", rdata, 8'h01);
    pen_up = 1; step(); rd(SA); chk("R8 pen_up clears", rdata, 8'h00);
    mode = 2'd0; ev_touch = 1; step();
    ev_touch = 1; rd(SA); chk("R11 read sees bit", rdata, 8'h01);
    rd(SA); chk("R11 set wins", rdata, 8'h01);

    void'($urandom(32'd12345));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(31) == 0) mode = 2'($urandom_range(3));
      ev_touch = ($urandom_range(3) == 0);
      ev_data  = ($urandom_range(3) == 0);
      ev_rel   = ($urandom_range(5) == 0);
      ev_err   = ($urandom_range(7) == 0);
      ev_port  = 3'($urandom_range(7)) & 3'($urandom_range(7));
      data_rd  = ($urandom_range(7) == 0);
      pen_up   = ($urandom_range(7) == 0);
      rd_en    = ($urandom_range(2) == 0);
      wr_en    = ($urandom_range(7) == 0);
      case ($urandom_range(3))
        0, 1: addr = SA;
        2: addr = IA;
        default: addr = 8'($urandom_range(255));
      endcase
      wdata = 8'($urandom_range(255));
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule